// File: doc/BRIEF.md
# Flash Status Register and Write-Lock Controller

This block keeps the eight-bit status byte of a serial flash device and decides which status changes are allowed. A command decoder reports each finished instruction as a one-cycle event carrying its opcode, the first data byte and whether that byte arrived complete. The block sets or clears the write-enable latch on those events. It accepts a status write only directly after the arming instruction. Whether that write is allowed then depends on the lock bit and the write-protect pin.

The operation sequencer supplies a busy level, a pulse that enters auto-increment programming, and a request that drops both the write-enable latch and the auto-increment bit. The two block-protect bits select a protected upper part of the array. Any address presented on the query port gets a combinational protected/unprotected answer. A load strobe copies the live status byte into a read latch once per output byte, so a status read shows fresh values on every byte, including while busy.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the status byte reads 0x0C: block-protect bits (bits 3:2) are 11, and busy (bit 0), write-enable latch (bit 1), auto-increment (bit 6) and lock (bit 7) are 0. The read latch resets to 0x00.
- R2: Opcode 0x06 sets bit 1. Opcode 0x04 clears bit 1 and bit 6.
- R3: A status write (opcode 0x01) changes the status only if the command event just before it carried opcode 0x50. Any other command after 0x50 disarms it, and a status write without that arming has no effect.
- R4: A status write is refused when the protect pin (wp_n) is low at its command event and bit 7 is 1. With wp_n low and bit 7 at 0, the write is accepted and may set bit 7.
- R5: With wp_n high the lock bit is ignored, and an armed write may clear bit 7.
- R6: An accepted write loads data bits 7, 3 and 2 into status bits 7, 3 and 2 in one step. Status bits 0, 1, 4, 5 and 6 are not taken from the data.
- R7: An armed status write whose data byte is incomplete (cmd_data_ok low) is discarded and also disarms, so a following 0x01 has no effect.
- R8: qry_prot_o is 1 for every address when bits 3:2 are 11. It is 1 only for addresses from 0x80000 up when they are 10, only from 0xC0000 up when they are 01, and never when they are 00.
- R9: Bit 0 follows busy_in one cycle later, and bits 5:4 always read 0.
- R10: aai_set sets bit 6. wel_clr clears bits 1 and 6 and wins over a 0x06 command or an aai_set in the same cycle.
- R11: rd_load copies the status byte of that cycle into rd_byte_o on the next edge, also while busy, so repeated loads show updated values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | One-cycle event: an instruction ended at chip-select rise |
| cmd_op | input | 8 | Opcode of the ended instruction |
| cmd_data | input | 8 | First data byte of the ended instruction |
| cmd_data_ok | input | 1 | The data byte was received complete |
| wp_n | input | 1 | Write-protect pin, low enables the lock |
| busy_in | input | 1 | Internal program/erase in progress |
| aai_set | input | 1 | Enter auto-increment programming |
| wel_clr | input | 1 | Sequencer request to drop write-enable and auto-increment |
| rd_load | input | 1 | Load status into the read latch (once per output byte) |
| qry_addr | input | 20 | Address to test against the protected range |
| status_o | output | 8 | Live status byte |
| rd_byte_o | output | 8 | Latched status byte for serial output |
| qry_prot_o | output | 1 | Queried address lies in the protected range |

## Verification
Status writes are tried after 0x50, without it, with another opcode in between, and with an incomplete data byte. These cases separate a design that checks only the previous instruction from one that remembers arming for longer. The lock is tried with all four combinations of pin level and lock state, using the data values 0x00, 0x84 and 0xFF. This shows that only bits 7, 3 and 2 move and that a pinned lock can be set but not cleared. Each protection level is queried at the address just below and at its boundary, and the simultaneous set/clear cases show which request has priority.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    typedef enum logic [0:0] {
        ARM_IDLE = 1'b0,
        ARM_OPEN = 1'b1
    } arm_state_t;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_EWSR = 8'h50;
    localparam logic [7:0] OP_WRSR = 8'h01;

    localparam int SR_W = 8;

    typedef struct packed {
        logic       bpl;
        logic       aai;
        logic [1:0] rsv;
        logic [1:0] bp;
        logic       wel;
        logic       busy;
    } status_t;

    localparam logic [1:0] BP_RESET = 2'b11;

endpackage

// File: rtl/fsu_arm_fsm.sv
module fsu_arm_fsm
    import fsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_op,
    input  logic       cmd_data_ok,
    output logic       wrsr_fire,
    output logic       armed
);

    arm_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_IDLE;
        else        state_q <= state_d;
    end

    // next state: every command event re-decides arming
    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            unique case (state_q)
                ARM_IDLE: state_d = (cmd_op == OP_EWSR) ? ARM_OPEN : ARM_IDLE;
                ARM_OPEN: state_d = (cmd_op == OP_EWSR) ? ARM_OPEN : ARM_IDLE;
                default:  state_d = ARM_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wrsr_fire = 1'b0;
        armed     = 1'b0;
        unique case (state_q)
            ARM_IDLE: armed = 1'b0;
            ARM_OPEN: begin
                armed     = 1'b1;
                wrsr_fire = cmd_valid && (cmd_op == OP_WRSR) && cmd_data_ok;
            end
            default:  armed = 1'b0;
        endcase
    end

endmodule

// File: rtl/fsu_lock_gate.sv
module fsu_lock_gate (
    input  logic       wrsr_fire,
    input  logic       wp_n,
    input  logic       bpl_q,
    input  logic [7:0] wr_data,
    output logic       wr_en,
    output logic [1:0] bp_new,
    output logic       bpl_new
);

    logic pin_releases;
    logic lock_open;

    // high pin overrides the lock; low pin honours it
    assign pin_releases = wp_n;
    assign lock_open    = pin_releases || !bpl_q;

    always_comb begin
        wr_en   = wrsr_fire && lock_open;
        bp_new  = wr_data[3:2];
        // accepted with the pin low implies lock was 0, so only 0->1 can occur
        bpl_new = wr_data[7];
    end

endmodule

// File: rtl/fsu_prot_map.sv
module fsu_prot_map #(
    parameter int ADDR_W = 20
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    logic upper_half;
    logic upper_quarter;

    assign upper_half    = addr[TOP];
    assign upper_quarter = addr[TOP] && addr[NXT];

    always_comb begin
        unique case (bp)
            2'b00:   hit = 1'b0;
            2'b01:   hit = upper_quarter;
            2'b10:   hit = upper_half;
            2'b11:   hit = 1'b1;
            default: hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
    import fsu_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [7:0]        cmd_data,
    input  logic              cmd_data_ok,
    input  logic              wp_n,
    input  logic              busy_in,
    input  logic              aai_set,
    input  logic              wel_clr,
    input  logic              rd_load,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic [7:0]        status_o,
    output logic [7:0]        rd_byte_o,
    output logic              qry_prot_o
);

    logic       busy_q, wel_q, aai_q, bpl_q;
    logic [1:0] bp_q;
    logic [SR_W-1:0] rd_q;
    logic       wrsr_fire, armed;
    logic       wr_en, bpl_new;
    logic [1:0] bp_new;
    logic       is_wren, is_wrdi;
    status_t    sr;

    fsu_arm_fsm u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_data_ok (cmd_data_ok),
        .wrsr_fire   (wrsr_fire),
        .armed       (armed)
    );

    fsu_lock_gate u_gate (
        .wrsr_fire (wrsr_fire),
        .wp_n      (wp_n),
        .bpl_q     (bpl_q),
        .wr_data   (cmd_data),
        .wr_en     (wr_en),
        .bp_new    (bp_new),
        .bpl_new   (bpl_new)
    );

    fsu_prot_map #(.ADDR_W(ADDR_W)) u_map (
        .bp   (bp_q),
        .addr (qry_addr),
        .hit  (qry_prot_o)
    );

    assign is_wren = cmd_valid && (cmd_op == OP_WREN);
    assign is_wrdi = cmd_valid && (cmd_op == OP_WRDI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wel_q  <= 1'b0;
            aai_q  <= 1'b0;
            bpl_q  <= 1'b0;
            bp_q   <= BP_RESET;
            rd_q   <= '0;
        end else begin
            busy_q <= busy_in;
            if (wel_clr || is_wrdi) wel_q <= 1'b0;
            else if (is_wren)       wel_q <= 1'b1;
            if (wel_clr || is_wrdi) aai_q <= 1'b0;
            else if (aai_set)       aai_q <= 1'b1;
            if (wr_en) begin
                bp_q  <= bp_new;
                bpl_q <= bpl_new;
            end
            if (rd_load) rd_q <= sr;
        end
    end

    always_comb begin
        sr.busy = busy_q;
        sr.wel  = wel_q;
        sr.bp   = bp_q;
        sr.rsv  = 2'b00;
        sr.aai  = aai_q;
        sr.bpl  = bpl_q;
    end

    assign status_o  = sr;
    assign rd_byte_o = rd_q;

endmodule

// File: rtl/fsu_checker.sv
module fsu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_op,
    input logic       cmd_data_ok,
    input logic       wp_n,
    input logic       busy_in,
    input logic       aai_set,
    input logic       wel_clr,
    input logic       rd_load,
    input logic [7:0] status_o,
    input logic [7:0] rd_byte_o,
    input logic       qry_prot_o
);

    logic [7:0] last_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         last_op <= 8'h00;
        else if (cmd_valid) last_op <= cmd_op;
    end

    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 8'h06 && !wel_clr) |=> status_o[1]);

    a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 8'h04) |=> (!status_o[1] && !status_o[6]));

    a_r3_unarmed_noeffect: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 8'h01 && last_op != 8'h50)
        |=> ($stable(status_o[7]) && $stable(status_o[3:2])));

    a_r4_locked_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wp_n && status_o[7])
        |=> (status_o[7] && $stable(status_o[3:2])));

    a_r7_partial_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 8'h01 && !cmd_data_ok)
        |=> ($stable(status_o[7]) && $stable(status_o[3:2])));

    a_r8_full_array: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b11) |-> qry_prot_o);

    a_r8_no_range: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b00) |-> !qry_prot_o);

    a_r9_busy_follow: assert property (@(posedge clk) disable iff (!rst_n)
        busy_in |=> status_o[0]);

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wel_clr && (aai_set || cmd_valid)) |=> (!status_o[1] && !status_o[6]));

    a_r11_read_load: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> (rd_byte_o == $past(status_o)));

endmodule

bind flash_status_unit fsu_checker u_fsu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_data_ok (cmd_data_ok),
    .wp_n        (wp_n),
    .busy_in     (busy_in),
    .aai_set     (aai_set),
    .wel_clr     (wel_clr),
    .rd_load     (rd_load),
    .status_o    (status_o),
    .rd_byte_o   (rd_byte_o),
    .qry_prot_o  (qry_prot_o)
);

// File: tb/tb_flash_status_unit.sv
`timescale 1ns/1ps
module tb_flash_status_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [7:0]  cmd_data = 8'h00;
    logic        cmd_data_ok = 1'b0;
    logic        wp_n = 1'b1;
    logic        busy_in = 1'b0;
    logic        aai_set = 1'b0;
    logic        wel_clr = 1'b0;
    logic        rd_load = 1'b0;
    logic [19:0] qry_addr = 20'h0;
    logic [7:0]  status_o, rd_byte_o;
    logic        qry_prot_o;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_status_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_data_ok(cmd_data_ok), .wp_n(wp_n),
        .busy_in(busy_in), .aai_set(aai_set), .wel_clr(wel_clr),
        .rd_load(rd_load), .qry_addr(qry_addr), .status_o(status_o),
        .rd_byte_o(rd_byte_o), .qry_prot_o(qry_prot_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // drive one command event for one cycle; returns after the update edge
    task automatic send(input logic [7:0] op, input logic [7:0] d, input logic ok, input logic pin);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_data_ok = ok; wp_n = pin;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_data_ok = 1'b0;
    endtask

    task automatic wr_status(input logic [7:0] d, input logic pin);
        send(8'h50, 8'h00, 1'b0, pin);
        send(8'h01, d, 1'b1, pin);
    endtask

    task automatic probe(input string tag, input logic [19:0] a, input logic exp);
        qry_addr = a;
        #1;
        check(tag, qry_prot_o, exp);
    endtask

    task automatic t_reset;
        check("R1 status reset", status_o, 8'h0C);
        check("R1 read latch reset", rd_byte_o, 8'h00);
        probe("R1/R8 reset protects low", 20'h00000, 1'b1);
    endtask

    task automatic t_wel;
        send(8'h06, 8'h00, 1'b0, 1'b1);
        check("R2 wren sets latch", status_o, 8'h0E);
        @(negedge clk); aai_set = 1'b1; @(negedge clk); aai_set = 1'b0;
        check("R10 aai set", status_o, 8'h4E);
        send(8'h04, 8'h00, 1'b0, 1'b1);
        check("R2 wrdi clears latch and aai", status_o, 8'h0C);
    endtask

    task automatic t_arming;
        send(8'h01, 8'h00, 1'b1, 1'b1);
        check("R3 unarmed write ignored", status_o, 8'h0C);
        send(8'h50, 8'h00, 1'b0, 1'b1);
        send(8'h06, 8'h00, 1'b0, 1'b1);
        send(8'h01, 8'h00, 1'b1, 1'b1);
        check("R3 intervening op disarms", status_o, 8'h0E);
        send(8'h04, 8'h00, 1'b0, 1'b1);
        wr_status(8'h00, 1'b1);
        check("R3 armed write accepted", status_o, 8'h00);
    endtask

    task automatic t_ranges;
        wr_status(8'h04, 1'b1);
        probe("R8 quarter boundary", 20'hC0000, 1'b1);
        probe("R8 below quarter", 20'hBFFFF, 1'b0);
        wr_status(8'h08, 1'b1);
        probe("R8 half boundary", 20'h80000, 1'b1);
        probe("R8 below half", 20'h7FFFF, 1'b0);
        wr_status(8'h00, 1'b1);
        probe("R8 none at top", 20'hFFFFF, 1'b0);
        wr_status(8'h0C, 1'b1);
        probe("R8 full at zero", 20'h00000, 1'b1);
    endtask

    task automatic t_lock;
        wr_status(8'hFF, 1'b1);
        check("R6 only bits 7,3,2 written; R9 reserved zero", status_o, 8'h8C);
        wr_status(8'h00, 1'b0);
        check("R4 locked write refused", status_o, 8'h8C);
        wr_status(8'h00, 1'b1);
        check("R5 pin high clears lock", status_o, 8'h00);
        wr_status(8'h84, 1'b0);
        check("R4 pin low may set lock", status_o, 8'h84);
        wr_status(8'h08, 1'b0);
        check("R4 lock cannot clear under pin", status_o, 8'h84);
        wr_status(8'h00, 1'b1);
        check("R5 release again", status_o, 8'h00);
    endtask

    task automatic t_partial;
        send(8'h50, 8'h00, 1'b0, 1'b1);
        send(8'h01, 8'h0C, 1'b0, 1'b1);
        check("R7 incomplete byte discarded", status_o, 8'h00);
        send(8'h01, 8'h0C, 1'b1, 1'b1);
        check("R7 discard also disarms", status_o, 8'h00);
    endtask

    task automatic t_busy_read;
        @(negedge clk); busy_in = 1'b1;
        @(negedge clk);
        check("R9 busy mirrored", status_o, 8'h01);
        rd_load = 1'b1; @(negedge clk); rd_load = 1'b0;
        check("R11 load during busy", rd_byte_o, 8'h01);
        send(8'h06, 8'h00, 1'b0, 1'b1);
        rd_load = 1'b1; @(negedge clk); rd_load = 1'b0;
        check("R11 next byte refreshed", rd_byte_o, 8'h03);
        busy_in = 1'b0; @(negedge clk);
        check("R9 busy drops", status_o, 8'h02);
    endtask

    task automatic t_priority;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 8'h06; wel_clr = 1'b1; aai_set = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; wel_clr = 1'b0; aai_set = 1'b0;
        check("R10 clear wins over set", status_o, 8'h00);
        @(negedge clk); aai_set = 1'b1; @(negedge clk); aai_set = 1'b0;
        send(8'h06, 8'h00, 1'b0, 1'b1);
        @(negedge clk); wel_clr = 1'b1; @(negedge clk); wel_clr = 1'b0;
        check("R10 clear request drops latch and aai", status_o, 8'h00);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wel();
        t_arming();
        t_ranges();
        t_lock();
        t_partial();
        t_busy_read();
        t_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule